// File: doc/BRIEF.md
# Lane Chain Sample Distributor

This block joins a row of identical processing lanes with a single register chain. Each lane holds one chain slot. The chain does two jobs.

In load mode it takes a block of frequency-domain complex samples from a valid/ready stream. It moves each sample down the chain one lane per clock. Each lane collects a contiguous group of subcarriers through its own load port, and a done pulse marks the end of the block.

In exchange mode every lane offers a value on its neighbour port. In one step every lane receives the value of the lane on one side. The lane at the end of the chain gets either zero or the value from the far end. This lets lanes that all run the same instruction still read an adjacent frequency point.

A command port selects load, exchange toward higher lanes or exchange toward lower lanes. The command port only takes a command while the chain is idle and empty.

Top module: `chain_distributor`

## Requirements
- R1: After reset, in_ready, nb_valid, load_done and every ld_valid bit are 0, and cmd_ready is 1.
- R2: A command with cmd_op=1 (load) that is accepted raises in_ready on the next cycle. in_ready stays high until NUM_SC samples have been accepted, and then it drops.
- R3: Accepted sample number k (counting from 0 within a block) appears exactly once on lane k/G, where G = NUM_SC/LANES. It appears with ld_idx = k mod G and unchanged data ({real[35:18], imag[17:0]}). No two lanes present a sample in the same cycle.
- R4: A sample accepted at clock edge e is presented on lane l's load port in the cycle after edge e+l. It moves one lane per clock, and there is no path other than lane to adjacent lane.
- R5: load_done is a one-cycle pulse that coincides with the last lane presenting index G-1. After it, cmd_ready returns to 1.
- R6: An accepted command with cmd_op=2 (shift up) makes nb_valid high for exactly the next cycle. In that cycle, nb_out of lane l equals the nb_in of lane l-1 that was present at acceptance.
- R7: An accepted command with cmd_op=3 (shift down) gives, in that next cycle, nb_out of lane l equal to the nb_in of lane l+1 that was present at acceptance.
- R8: With cmd_wrap=0, the end lane that has no source neighbour gets zero. This is lane 0 for shift up and lane LANES-1 for shift down.
- R9: With cmd_wrap=1, the end lane takes the opposite end's value instead. Lane 0 takes lane LANES-1 on shift up, and lane LANES-1 takes lane 0 on shift down.
- R10: While a load is in progress, cmd_ready is 0 and commands have no effect: no nb_valid appears. When no load is active, in_ready is 0, and in_valid causes no ld_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample ready |
| in_data | input | 2*DW | Sample {real, imag} |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted when high |
| cmd_op | input | 2 | 0 none, 1 load, 2 shift up, 3 shift down |
| cmd_wrap | input | 1 | End lane wraps instead of getting zero |
| ld_valid | output | LANES | Per-lane load strobe |
| ld_idx | output | LANES*IW | Per-lane index within its group |
| ld_data | output | LANES*2*DW | Per-lane loaded sample |
| nb_in | input | LANES*2*DW | Per-lane value offered for exchange |
| nb_out | output | LANES*2*DW | Per-lane value received (chain slot) |
| nb_valid | output | 1 | nb_out holds an exchange result |
| load_done | output | 1 | Block fully delivered |

## Verification
The assertions check these properties on every cycle:
- the stream and the command port are never open together;
- an exchange result follows only an accepted shift command, by one cycle;
- load strobes are at most one-hot and never coincide with an exchange result;
- the done pulse is single and sits on the last lane;
- a non-wrapping shift up leaves lane 0 at zero.

The mapping of every sample to its lane and index, the lane-by-lane data movement in both directions, the wrap values, and stream stalls with gaps only show up in the bench's directed scenarios. In those scenarios, values are compared against an independently computed pattern.

// File: rtl/chain_pkg.sv
package chain_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_UP   = 2'd2,
    OP_DOWN = 2'd3
  } chain_op_e;

  // lane that owns subcarrier k when each lane owns g consecutive ones
  function automatic int unsigned owner_lane(input int unsigned k, input int unsigned g);
    return k / g;
  endfunction

  // position of subcarrier k inside its owner's group
  function automatic int unsigned group_pos(input int unsigned k, input int unsigned g);
    return k % g;
  endfunction
endpackage

// File: rtl/chain_stage.sv
module chain_stage #(
  parameter int LANE = 0,
  parameter int LW   = 3,
  parameter int IW   = 5,
  parameter int CW   = 36,
  localparam int SW  = 1 + LW + IW + CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_go,
  input  logic [CW-1:0] shift_val,
  input  logic [SW-1:0] adv_in,
  output logic [SW-1:0] slot_q,
  output logic          hit
);
  always_ff @(posedge clk) begin
    if (!rst_n)        slot_q <= '0;
    else if (shift_go) slot_q <= {1'b0, {(LW+IW){1'b0}}, shift_val};
    else               slot_q <= adv_in;
  end

  assign hit = slot_q[SW-1] && (slot_q[CW+IW +: LW] == LW'(LANE));
endmodule

// File: rtl/load_ctrl.sv
module load_ctrl #(
  parameter int NUM_SC = 256,
  localparam int KW    = $clog2(NUM_SC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  input  logic          last_hit,
  output logic          in_ready,
  output logic          accept,
  output logic [KW-1:0] sample_k,
  output logic          loading
);
  logic [KW-1:0] cnt_q;

  assign in_ready = loading && (cnt_q < KW'(NUM_SC));
  assign accept   = in_valid && in_ready;
  assign sample_k = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loading <= 1'b0;
      cnt_q   <= '0;
    end else if (start) begin
      loading <= 1'b1;
      cnt_q   <= '0;
    end else begin
      if (accept)   cnt_q   <= cnt_q + 1'b1;
      if (last_hit) loading <= 1'b0;
    end
  end
endmodule

// File: rtl/chain_distributor.sv
module chain_distributor #(
  parameter int LANES  = 8,
  parameter int DW     = 18,
  parameter int NUM_SC = 256,
  localparam int G     = NUM_SC / LANES,
  localparam int LW    = $clog2(LANES),
  localparam int IW    = $clog2(G),
  localparam int CW    = 2 * DW,
  localparam int KW    = $clog2(NUM_SC + 1),
  localparam int SW    = 1 + LW + IW + CW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [CW-1:0]       in_data,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [1:0]          cmd_op,
  input  logic                cmd_wrap,
  output logic [LANES-1:0]    ld_valid,
  output logic [LANES*IW-1:0] ld_idx,
  output logic [LANES*CW-1:0] ld_data,
  input  logic [LANES*CW-1:0] nb_in,
  output logic [LANES*CW-1:0] nb_out,
  output logic                nb_valid,
  output logic                load_done
);
  import chain_pkg::*;

  logic [SW-1:0] slot  [LANES];
  logic [SW-1:0] adv   [LANES];
  logic [CW-1:0] src   [LANES];
  logic [LANES-1:0] hit;
  logic [LANES-1:0] occ;
  logic cmd_fire, start, shift_go, shift_up, accept, loading, chain_empty, last_hit;
  logic [KW-1:0] sample_k;

  assign cmd_fire    = cmd_valid && cmd_ready;
  assign start       = cmd_fire && (cmd_op == OP_LOAD);
  assign shift_go    = cmd_fire && (cmd_op == OP_UP || cmd_op == OP_DOWN);
  assign shift_up    = (cmd_op == OP_UP);
  assign chain_empty = (occ == '0);
  assign cmd_ready   = !loading && chain_empty;
  assign last_hit    = hit[LANES-1] && (slot[LANES-1][CW +: IW] == IW'(G - 1));
  assign load_done   = last_hit;

  load_ctrl #(.NUM_SC(NUM_SC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .last_hit(last_hit), .in_ready(in_ready), .accept(accept),
    .sample_k(sample_k), .loading(loading)
  );

  // entry slot: tag the accepted sample with its owner lane and position
  assign adv[0] = {accept,
                   LW'(owner_lane(int'(sample_k), G)),
                   IW'(group_pos(int'(sample_k), G)),
                   in_data};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // forwarded slot loses its valid bit once the owning lane took it
    if (l > 0) begin : g_adv
      assign adv[l] = {slot[l-1][SW-1] && !hit[l-1], slot[l-1][SW-2:0]};
    end

    // neighbour source for each direction, with end-of-chain handling
    logic [CW-1:0] from_low, from_high;
    if (l == 0) begin : g_lo_end
      assign from_low = cmd_wrap ? nb_in[(LANES-1)*CW +: CW] : '0;
    end else begin : g_lo_mid
      assign from_low = nb_in[(l-1)*CW +: CW];
    end
    if (l == LANES-1) begin : g_hi_end
      assign from_high = cmd_wrap ? nb_in[0 +: CW] : '0;
    end else begin : g_hi_mid
      assign from_high = nb_in[(l+1)*CW +: CW];
    end
    assign src[l] = shift_up ? from_low : from_high;

    chain_stage #(.LANE(l), .LW(LW), .IW(IW), .CW(CW)) u_stage (
      .clk(clk), .rst_n(rst_n), .shift_go(shift_go), .shift_val(src[l]),
      .adv_in(adv[l]), .slot_q(slot[l]), .hit(hit[l])
    );

    assign occ[l]                = slot[l][SW-1];
    assign ld_valid[l]           = hit[l];
    assign ld_idx[l*IW +: IW]    = slot[l][CW +: IW];
    assign ld_data[l*CW +: CW]   = slot[l][CW-1:0];
    assign nb_out[l*CW +: CW]    = slot[l][CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) nb_valid <= 1'b0;
    else        nb_valid <= shift_go;
  end
endmodule

// File: rtl/chain_distributor_chk.sv
module chain_distributor_chk #(
  parameter int LANES = 8,
  parameter int CW    = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic             cmd_wrap,
  input logic [LANES-1:0] ld_valid,
  input logic [CW-1:0]    nb_out0,
  input logic             nb_valid,
  input logic             load_done
);
  AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !cmd_ready); // R10
  AST_NB_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    nb_valid |-> $past(cmd_valid && cmd_ready && cmd_op[1])); // R6
  AST_NB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op[1]) |=> nb_valid); // R6
  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_valid)); // R3
  AST_NO_LOAD_IN_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    nb_valid |-> (ld_valid == '0)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done); // R5
  AST_DONE_LAST_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> ld_valid[LANES-1]); // R5
  AST_UP_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'd2 && !cmd_wrap) |=> (nb_out0 == '0)); // R8
endmodule

bind chain_distributor chain_distributor_chk #(.LANES(LANES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_wrap(cmd_wrap),
  .ld_valid(ld_valid), .nb_out0(nb_out[CW-1:0]), .nb_valid(nb_valid),
  .load_done(load_done)
);

// File: tb/chain_distributor_bench.sv
module chain_distributor_bench;
  localparam int L  = 8;
  localparam int DW = 18;
  localparam int NS = 256;
  localparam int G  = NS / L;
  localparam int IW = $clog2(G);
  localparam int CW = 2 * DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [CW-1:0] in_data = '0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic cmd_wrap = 1'b0;
  logic [L-1:0] ld_valid;
  logic [L*IW-1:0] ld_idx;
  logic [L*CW-1:0] ld_data;
  logic [L*CW-1:0] nb_in = '0;
  logic [L*CW-1:0] nb_out;
  logic nb_valid;
  logic load_done;

  int tests = 0;
  int fails = 0;
  int seed_cur = 0;
  int lane_cnt [L];
  int done_seen = 0;

  always #10 clk = ~clk;

  chain_distributor #(.LANES(L), .DW(DW), .NUM_SC(NS)) u_chain_distributor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wrap(cmd_wrap), .ld_valid(ld_valid),
    .ld_idx(ld_idx), .ld_data(ld_data), .nb_in(nb_in), .nb_out(nb_out),
    .nb_valid(nb_valid), .load_done(load_done)
  );

  function automatic logic [CW-1:0] pat(input int k, input int s);
    logic [DW-1:0] re, im;
    re = DW'(k * 7 + s);
    im = DW'((k << 3) ^ (s * 5 + 18'h15A5));
    return {re, im};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // load-port monitor: lane l must see subcarriers l*G .. l*G+G-1 in order (R3, R4)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < L; l++) begin
        if (ld_valid[l]) begin
          check(ld_idx[l*IW +: IW] == IW'(lane_cnt[l]), "R3", "lane index",
                ld_idx[l*IW +: IW], lane_cnt[l]);
          check(ld_data[l*CW +: CW] == pat(l * G + lane_cnt[l], seed_cur), "R4", "lane data",
                ld_data[l*CW +: CW], pat(l * G + lane_cnt[l], seed_cur));
          lane_cnt[l]++;
        end
      end
      if (load_done) begin
        done_seen++;
        check(ld_valid[L-1] && ld_idx[(L-1)*IW +: IW] == IW'(G-1), "R5", "done position",
              ld_idx[(L-1)*IW +: IW], G-1);
      end
    end
  end

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R1", "in_ready", in_ready, 0);
    check(cmd_ready == 1'b1, "R1", "cmd_ready", cmd_ready, 1);
    check(nb_valid == 1'b0 && load_done == 1'b0, "R1", "nb_valid/done", {nb_valid, load_done}, 0);
    check(ld_valid == '0, "R1", "ld_valid", ld_valid, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_idle_stream();
    in_valid = 1'b1;
    in_data  = pat(3, 9);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(in_ready == 1'b0 && ld_valid == '0, "R10", "idle stream ignored",
            {in_ready, ld_valid}, 0);
    end
    in_valid = 1'b0;
  endtask

  task automatic t_load(input int gap, input int poke_at, input int seed);
    int k;
    int cyc;
    int d0;
    bit poke_chk;
    seed_cur = seed;
    for (int l = 0; l < L; l++) lane_cnt[l] = 0;
    d0 = done_seen;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R5", "cmd_ready before load", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_op = 2'd1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd0;
    check(in_ready == 1'b1, "R2", "in_ready after load cmd", in_ready, 1);
    k = 0; cyc = 0; poke_chk = 1'b0;
    while (k < NS) begin
      if (poke_chk) begin
        check(nb_valid == 1'b0, "R10", "command during load", nb_valid, 0);
        poke_chk = 1'b0;
        cmd_valid = 1'b0; cmd_op = 2'd0;
      end
      if (k == poke_at && cmd_op == 2'd0 && cyc > 0) begin
        check(cmd_ready == 1'b0, "R10", "cmd_ready during load", cmd_ready, 0);
        cmd_valid = 1'b1; cmd_op = 2'd2; poke_chk = 1'b1;
      end
      if (gap > 0 && (cyc % gap) == gap - 1) begin
        in_valid = 1'b0;
      end else if (in_ready) begin
        in_valid = 1'b1; in_data = pat(k, seed); k++;
      end else begin
        in_valid = 1'b0;
      end
      cyc++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    cmd_valid = 1'b0; cmd_op = 2'd0;
    check(in_ready == 1'b0, "R2", "in_ready after full block", in_ready, 0);
    for (int w = 0; w < 200 && done_seen == d0; w++) @(negedge clk);
    @(negedge clk);
    check(done_seen == d0 + 1, "R5", "done pulses", done_seen - d0, 1);
    for (int l = 0; l < L; l++)
      check(lane_cnt[l] == G, "R3", "samples per lane", lane_cnt[l], G);
    check(cmd_ready == 1'b1 && in_ready == 1'b0, "R5", "idle after done", {cmd_ready, in_ready}, 2);
  endtask

  task automatic t_shift(input bit up, input bit wrap, input int seed);
    logic [CW-1:0] v [L];
    logic [CW-1:0] e;
    string rq;
    @(negedge clk);
    for (int l = 0; l < L; l++) begin
      v[l] = pat(500 + l, seed);
      nb_in[l*CW +: CW] = v[l];
    end
    check(cmd_ready == 1'b1, "R6", "cmd_ready before shift", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_op = up ? 2'd2 : 2'd3; cmd_wrap = wrap;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd0;
    nb_in = '0;
    check(nb_valid == 1'b1, "R6", "nb_valid after shift", nb_valid, 1);
    for (int l = 0; l < L; l++) begin
      if (up) begin
        rq = "R6";
        if (l == 0) begin e = wrap ? v[L-1] : '0; rq = wrap ? "R9" : "R8"; end
        else e = v[l-1];
      end else begin
        rq = "R7";
        if (l == L-1) begin e = wrap ? v[0] : '0; rq = wrap ? "R9" : "R8"; end
        else e = v[l+1];
      end
      check(nb_out[l*CW +: CW] == e, rq, "neighbour value", nb_out[l*CW +: CW], e);
    end
    @(negedge clk);
    check(nb_valid == 1'b0, "R6", "nb_valid one cycle", nb_valid, 0);
    cmd_wrap = 1'b0;
  endtask

  initial begin
    t_reset();
    t_idle_stream();
    t_load(0, -1, 11);
    t_shift(1'b1, 1'b0, 3);
    t_shift(1'b0, 1'b0, 4);
    t_shift(1'b1, 1'b1, 5);
    t_shift(1'b0, 1'b1, 6);
    t_load(3, 40, 27);
    t_shift(1'b1, 1'b0, 8);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule